// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a three-wire serial EEPROM link. Internal logic hands it one command at a time over a valid/ready request port. Each request carries a command code, a word address, write data and a word-size select. The controller raises chip select and produces a shift clock divided down from the system clock. It then sends the start bit, the two-bit opcode, the address and, where the command has one, the data word, most significant bit first.

For a read, the controller discards the leading zero that the memory sends before its data, and collects the data word. For a command that programs the array, the controller drops chip select for a guard time and raises it again. It then watches the data-out line until the memory reports ready or a timeout counter expires. Every request ends with a one-cycle response that carries the read word and a timeout flag.

All link timing is counted in system clocks through parameters, so the same block can serve a fast or a slow memory at any system clock rate. The transmitted address length is a parameter as well, which covers arrays whose top address bit is ignored but must still be clocked.

Top module: `sprom_host`

## Requirements
- R1: While reset is asserted and directly after it, chip select and shift clock are low, `rsp_valid` is low and `req_ready` is high.
- R2: A frame is a 1 start bit, then a 2-bit opcode (read 10, write 01, erase 11, all others 00), then the address MSB first, then for write and write-all the data MSB first. Address length is ADDR_W bits when `req_wide`=0 (8-bit words) and ADDR_W-1 bits when `req_wide`=1 (16-bit words). `req_op` codes: 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 erase-all, 6 write-all; code 7 is sent as a disable.
- R3: Enable, disable, erase-all and write-all use opcode 00 and put 11, 00, 10 and 01 in the two most significant address positions, with the other address bits sent as 0.
- R4: On a read, the bit sampled on the falling clock edge of the last address bit is discarded. The next 8 or 16 sampled bits are returned MSB first on `rsp_rdata`, zero-extended in 8-bit mode.
- R5: Shift clock high and low phases each last exactly HALF system clocks inside a frame, and the data line changes only while the shift clock is low.
- R6: Chip select is high for HALF clocks before the first rising shift-clock edge. It stays low for at least GAP clocks before every rise, and the shift clock is low whenever chip select is low.
- R7: After write, erase, erase-all and write-all, the controller holds chip select low for GAP clocks and then raises it with no shift-clock pulses. It waits HALF clocks, then samples data-out every clock, and finishes when it reads 1, with `rsp_timeout`=0.
- R8: If data-out has not read 1 within TIMEOUT clocks of the status chip-select rise, the command ends with `rsp_timeout`=1.
- R9: `req_ready` is high only when idle. It goes low on acceptance and stays low until `rsp_valid` has been high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_op | input | 3 | Command code (see R2) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data (low byte in 8-bit mode) |
| req_wide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 16 | Read word |
| rsp_timeout | output | 1 | Ready was not seen in time |
| mem_cs | output | 1 | Memory chip select |
| mem_sck | output | 1 | Memory shift clock |
| mem_di | output | 1 | Serial data to the memory |
| mem_do | input | 1 | Serial data / ready status from the memory |

## Verification
The bench targets the off-by-one in read capture. A design that keeps the leading zero would return every byte shifted right by one with its low bit lost, and the full address sweeps in both word sizes expose that at once. Extended commands are checked through their effect: a wrong code in the address field either fails to unlock programming or fails to fill or clear the array. The reserved code must lock the array. The status phase is checked for a frame with zero clock edges and for a memory that stays busy past the limit, where a missing timeout would hang or report success falsely. Clock widths, data stability while the clock is high, and the chip-select low time are measured on every frame.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
    typedef enum logic [2:0] {
        CMD_READ      = 3'd0,
        CMD_WRITE     = 3'd1,
        CMD_ERASE     = 3'd2,
        CMD_ENABLE    = 3'd3,
        CMD_DISABLE   = 3'd4,
        CMD_ERASE_ALL = 3'd5,
        CMD_WRITE_ALL = 3'd6,
        CMD_RSVD      = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SHIFT = 3'd1,
        ST_PRE   = 3'd2,
        ST_POLL  = 3'd3,
        ST_GAP   = 3'd4,
        ST_DONE  = 3'd5
    } st_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_ERASE = 2'b11;
    localparam logic [1:0] OPC_EXT   = 2'b00;

    localparam logic [1:0] SUB_ENABLE    = 2'b11;
    localparam logic [1:0] SUB_DISABLE   = 2'b00;
    localparam logic [1:0] SUB_ERASE_ALL = 2'b10;
    localparam logic [1:0] SUB_WRITE_ALL = 2'b01;
endpackage

// File: rtl/sprom_timer.sv
module sprom_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sprom_frame.sv
module sprom_frame
    import sprom_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int FRAME_W = 3 + ADDR_W + 16,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  cmd_e               op,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [15:0]        wdata,
    input  logic               wide,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits,
    output logic [CNT_W-1:0]   cap_from,
    output logic               is_read,
    output logic               needs_poll
);
    localparam int AW16 = ADDR_W - 1;

    logic [1:0]        opc;
    logic [1:0]        sub;
    logic              ext;
    logic              has_data;
    logic [ADDR_W-1:0] af8;
    logic [AW16-1:0]   af16;
    logic [15:0]       dat;
    int                alen;
    int                dlen;

    always_comb begin
        opc        = OPC_EXT;
        sub        = SUB_DISABLE;
        ext        = 1'b1;
        has_data   = 1'b0;
        is_read    = 1'b0;
        needs_poll = 1'b0;
        case (op)
            CMD_READ:      begin opc = OPC_READ;  ext = 1'b0; is_read = 1'b1; end
            CMD_WRITE:     begin opc = OPC_WRITE; ext = 1'b0; has_data = 1'b1; needs_poll = 1'b1; end
            CMD_ERASE:     begin opc = OPC_ERASE; ext = 1'b0; needs_poll = 1'b1; end
            CMD_ENABLE:    sub = SUB_ENABLE;
            CMD_ERASE_ALL: begin sub = SUB_ERASE_ALL; needs_poll = 1'b1; end
            CMD_WRITE_ALL: begin sub = SUB_WRITE_ALL; has_data = 1'b1; needs_poll = 1'b1; end
            default:       sub = SUB_DISABLE;
        endcase

        af8  = ext ? (ADDR_W'(sub) << (ADDR_W - 2)) : addr;
        af16 = ext ? (AW16'(sub) << (AW16 - 2)) : addr[AW16-1:0];
        dat  = has_data ? wdata : 16'h0000;

        if (wide) frame = {1'b1, opc, af16, dat, 1'b0};
        else      frame = {1'b1, opc, af8, dat[7:0], 8'h00};

        alen     = wide ? AW16 : ADDR_W;
        dlen     = wide ? 16 : 8;
        nbits    = CNT_W'(3 + alen + ((is_read || has_data) ? dlen : 0));
        cap_from = CNT_W'(3 + alen);
    end
endmodule

// File: rtl/sprom_host.sv
module sprom_host
    import sprom_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int HALF    = 25,
    parameter int GAP     = 25,
    parameter int TIMEOUT = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic              req_wide,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic              rsp_timeout,
    output logic              mem_cs,
    output logic              mem_sck,
    output logic              mem_di,
    input  logic              mem_do
);
    localparam int FRAME_W = 3 + ADDR_W + 16;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int PH_MAX  = (HALF > GAP) ? HALF : GAP;
    localparam int PH_W    = $clog2(PH_MAX + 1);
    localparam int TO_W    = $clog2(TIMEOUT + 1);

    typedef struct packed {
        st_e                st;
        logic               cs;
        logic               sck;
        logic               di;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   bitn;
        logic [CNT_W-1:0]   nbits;
        logic [CNT_W-1:0]   cap_from;
        logic               rd;
        logic               poll;
        logic               tmo;
        logic [15:0]        rdata;
    } regs_t;

    regs_t d, q;

    logic [FRAME_W-1:0] f_frame;
    logic [CNT_W-1:0]   f_nbits, f_cap;
    logic               f_rd, f_poll;
    logic               ph_load, ph_zero, to_load, to_zero;
    logic [PH_W-1:0]    ph_val;

    sprom_frame #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
        .op        (cmd_e'(req_op)),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .wide      (req_wide),
        .frame     (f_frame),
        .nbits     (f_nbits),
        .cap_from  (f_cap),
        .is_read   (f_rd),
        .needs_poll(f_poll)
    );

    sprom_timer #(.W(PH_W)) u_phase (
        .clk (clk),
        .rst_n(rst_n),
        .load(ph_load),
        .val (ph_val),
        .zero(ph_zero)
    );

    sprom_timer #(.W(TO_W)) u_limit (
        .clk (clk),
        .rst_n(rst_n),
        .load(to_load),
        .val (TO_W'(TIMEOUT - 1)),
        .zero(to_zero)
    );

    always_comb begin
        d       = q;
        ph_load = 1'b0;
        ph_val  = PH_W'(HALF - 1);
        to_load = 1'b0;
        case (q.st)
            ST_IDLE: begin
                d.cs  = 1'b0;
                d.sck = 1'b0;
                if (req_valid) begin
                    d.frame    = f_frame;
                    d.nbits    = f_nbits;
                    d.cap_from = f_cap;
                    d.rd       = f_rd;
                    d.poll     = f_poll;
                    d.tmo      = 1'b0;
                    d.rdata    = '0;
                    d.bitn     = '0;
                    d.cs       = 1'b1;
                    d.di       = f_frame[FRAME_W-1];
                    ph_load    = 1'b1;
                    d.st       = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (ph_zero) begin
                    ph_load = 1'b1;
                    if (!q.sck) begin
                        d.sck = 1'b1;
                    end else begin
                        d.sck = 1'b0;
                        if (q.rd && (q.bitn >= q.cap_from)) begin
                            d.rdata = {q.rdata[14:0], mem_do};
                        end
                        if (q.bitn == q.nbits - 1'b1) begin
                            d.cs   = 1'b0;
                            d.di   = 1'b0;
                            ph_val = PH_W'(GAP - 1);
                            d.st   = q.poll ? ST_PRE : ST_GAP;
                        end else begin
                            d.bitn  = q.bitn + 1'b1;
                            d.frame = q.frame << 1;
                            d.di    = q.frame[FRAME_W-2];
                        end
                    end
                end
            end
            ST_PRE: begin
                if (ph_zero) begin
                    d.cs    = 1'b1;
                    ph_load = 1'b1;
                    to_load = 1'b1;
                    d.st    = ST_POLL;
                end
            end
            ST_POLL: begin
                if (ph_zero) begin
                    if (mem_do || to_zero) begin
                        d.tmo   = !mem_do;
                        d.cs    = 1'b0;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(GAP - 1);
                        d.st    = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (ph_zero) d.st = ST_DONE;
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign rsp_valid   = (q.st == ST_DONE);
    assign rsp_rdata   = q.rdata;
    assign rsp_timeout = q.tmo;
    assign mem_cs      = q.cs;
    assign mem_sck     = q.sck;
    assign mem_di      = q.di;
endmodule

// File: rtl/sprom_host_chk.sv
module sprom_host_chk #(
    parameter int HALF = 25,
    parameter int GAP  = 25
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_valid,
    input logic mem_cs,
    input logic mem_sck,
    input logic mem_di
);
    int hi_cnt, lo_cnt, csl_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt  <= 0;
            lo_cnt  <= 0;
            csl_cnt <= GAP;
        end else begin
            hi_cnt  <= mem_sck ? hi_cnt + 1 : 0;
            lo_cnt  <= (mem_cs && !mem_sck) ? lo_cnt + 1 : 0;
            csl_cnt <= !mem_cs ? ((csl_cnt < GAP) ? csl_cnt + 1 : csl_cnt) : 0;
        end
    end

    // R5
    sck_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_sck) |-> hi_cnt == HALF);
    // R5
    sck_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_sck) |-> lo_cnt == HALF);
    // R5
    di_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sck |-> $stable(mem_di));
    // R6
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs) |-> csl_cnt >= GAP);
    // R6
    sck_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs |-> !mem_sck);
    // R9
    busy_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9
    idle_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_cs);
endmodule

bind sprom_host sprom_host_chk #(.HALF(HALF), .GAP(GAP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_cs   (mem_cs),
    .mem_sck  (mem_sck),
    .mem_di   (mem_di)
);

// File: tb/sim_sprom_host.sv
module sim_sprom_host;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 7;
    localparam int HALF = 2;
    localparam int GAP  = 3;
    localparam int TMO  = 200;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_wide = 0;
    logic [2:0] req_op = 0;
    logic [AW-1:0] req_addr = 0;
    logic [15:0] req_wdata = 0;
    logic req_ready, rsp_valid, rsp_timeout, mem_cs, mem_sck, mem_di, mem_do;
    logic [15:0] rsp_rdata;

    int errors = 0, checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sprom_host #(.ADDR_W(AW), .HALF(HALF), .GAP(GAP), .TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_wide(req_wide),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
        .mem_cs(mem_cs), .mem_sck(mem_sck), .mem_di(mem_di), .mem_do(mem_do));

    // ---------------- memory model ----------------
    logic [7:0] mem8 [128];
    bit wide_dev = 0, en = 0, started = 0, rd_act = 0, dout = 0, sck_p = 0;
    int nb = 0, sh = 0, rbuf = 0, busy = 0, busy_len = 40;

    function automatic int rd_word(int a, bit w);
        return w ? ((int'(mem8[2*a+1]) << 8) | int'(mem8[2*a])) : int'(mem8[a]);
    endfunction

    task automatic wr_word(int a, int v, bit w);
        if (w) begin mem8[2*a] = v[7:0]; mem8[2*a+1] = v[15:8]; end
        else mem8[a] = v[7:0];
    endtask

    always @(posedge clk) begin
        int al, dl, opc, ad, top2, dat;
        al = wide_dev ? AW - 1 : AW;
        dl = wide_dev ? 16 : 8;
        if (busy > 0) busy = busy - 1;
        if (!mem_cs) begin
            started = 0; nb = 0; rd_act = 0;
        end else if (mem_sck && !sck_p) begin
            if (!started) begin
                if (mem_di) begin started = 1; nb = 0; sh = 0; end
            end else if (rd_act) begin
                dout = rbuf[dl-1];
                rbuf = rbuf << 1;
            end else begin
                sh = (sh << 1) | int'(mem_di);
                nb = nb + 1;
                if (nb == 2 + al) begin
                    opc = (sh >> al) & 3;
                    ad = sh & ((1 << al) - 1);
                    top2 = ad >> (al - 2);
                    if (opc == 2) begin
                        rd_act = 1; dout = 0; rbuf = rd_word(ad, wide_dev);
                    end else if (opc == 3) begin
                        if (en) begin wr_word(ad, 16'hFFFF, wide_dev); busy = busy_len; end
                    end else if (opc == 0) begin
                        if (top2 == 3) en = 1;
                        else if (top2 == 0) en = 0;
                        else if (top2 == 2 && en) begin
                            for (int i = 0; i < 128; i++) mem8[i] = 8'hFF;
                            busy = busy_len;
                        end
                    end
                end else if (nb == 2 + al + dl) begin
                    dat = sh & ((1 << dl) - 1);
                    ad = (sh >> dl) & ((1 << al) - 1);
                    opc = (sh >> (dl + al)) & 3;
                    top2 = ad >> (al - 2);
                    if (en && opc == 1) begin wr_word(ad, dat, wide_dev); busy = busy_len; end
                    if (en && opc == 0 && top2 == 1) begin
                        for (int i = 0; i < (wide_dev ? 64 : 128); i++) wr_word(i, dat, wide_dev);
                        busy = busy_len;
                    end
                end
            end
        end
        sck_p = mem_sck;
    end

    assign mem_do = rd_act ? dout : (busy == 0);

    // ---------------- link monitor ----------------
    int tviol = 0, hi_run = 0, lo_run = GAP, win_edges = 0, last_win = 0, prev_win = 0;
    logic m_sck = 0, m_cs = 0, m_di = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_sck && !m_sck) win_edges++;
            if (mem_sck) hi_run++;
            else begin
                if (m_sck && hi_run != HALF) tviol++;
                hi_run = 0;
            end
            if (mem_sck && mem_di != m_di) tviol++;
            if (mem_sck && !mem_cs) tviol++;
            if (!mem_cs) lo_run++;
            else begin
                if (!m_cs && lo_run < GAP) tviol++;
                lo_run = 0;
            end
            if (!mem_cs && m_cs) begin
                prev_win = last_win; last_win = win_edges; win_edges = 0;
            end
        end
        m_sck = mem_sck; m_cs = mem_cs; m_di = mem_di;
    end

    // ---------------- helpers ----------------
    int hs_err = 0;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(int op, int addr, int data, bit wide, output int rdata, output bit tmo);
        wide_dev = wide;
        @(negedge clk);
        if (!req_ready) hs_err++;
        req_valid = 1; req_op = op[2:0]; req_addr = addr[AW-1:0];
        req_wdata = data[15:0]; req_wide = wide;
        @(negedge clk);
        req_valid = 0;
        while (!rsp_valid) begin
            if (req_ready) hs_err++;
            @(negedge clk);
        end
        rdata = int'(rsp_rdata);
        tmo = rsp_timeout;
        @(negedge clk);
        if (rsp_valid || !req_ready) hs_err++;
    endtask

    function automatic int pat8(int a);
        return (a * 29 + 7) & 255;
    endfunction

    function automatic int pat16(int w);
        return (w * 40503 + 4660) & 65535;
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        int rd;
        bit tmo;
        for (int i = 0; i < 128; i++) mem8[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!mem_cs && !mem_sck && !rsp_valid, "R1 reset outputs", {mem_cs, mem_sck, rsp_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        check(req_ready == 1, "R1 ready after reset", req_ready, 1);

        // R3 enable, then byte-mode sweep (R2, R7)
        do_cmd(3, 0, 0, 0, rd, tmo);
        for (int a = 0; a < 128; a++) begin
            do_cmd(1, a, pat8(a), 0, rd, tmo);
            check(tmo == 0, "R7 write ready seen", tmo, 0);
            if (a == 0) begin
                check(prev_win == 18, "R2 byte write frame edges", prev_win, 18);
                check(last_win == 0, "R7 status phase has no clock", last_win, 0);
            end
        end
        for (int a = 0; a < 128; a++) begin
            do_cmd(0, a, 0, 0, rd, tmo);
            check(rd == pat8(a), "R4 byte read", rd, pat8(a));
        end
        check(last_win == 18, "R4 byte read frame edges", last_win, 18);

        // word-mode sweep (R2, R4)
        for (int w = 0; w < 64; w++) begin
            do_cmd(1, w, pat16(w), 1, rd, tmo);
            if (w == 0) check(prev_win == 25, "R2 word write frame edges", prev_win, 25);
        end
        for (int w = 0; w < 64; w++) begin
            do_cmd(0, w, 0, 1, rd, tmo);
            check(rd == pat16(w), "R4 word read", rd, pat16(w));
        end

        // R2 erase one word
        do_cmd(2, 9, 0, 1, rd, tmo);
        check(prev_win == 9, "R2 erase frame edges", prev_win, 9);
        do_cmd(0, 9, 0, 1, rd, tmo);
        check(rd == 16'hFFFF, "R2 erase result", rd, 16'hFFFF);

        // R3 disable locks programming
        do_cmd(4, 0, 0, 1, rd, tmo);
        do_cmd(1, 10, 0, 1, rd, tmo);
        do_cmd(0, 10, 0, 1, rd, tmo);
        check(rd == pat16(10), "R3 disable blocks write", rd, pat16(10));

        // R2 reserved code acts as disable
        do_cmd(3, 0, 0, 1, rd, tmo);
        do_cmd(7, 0, 0, 1, rd, tmo);
        do_cmd(1, 11, 0, 1, rd, tmo);
        do_cmd(0, 11, 0, 1, rd, tmo);
        check(rd == pat16(11), "R2 reserved code locks", rd, pat16(11));

        // R3 write-all and erase-all
        do_cmd(3, 0, 0, 1, rd, tmo);
        do_cmd(6, 0, 16'h5AA5, 1, rd, tmo);
        check(prev_win == 25, "R3 write-all frame edges", prev_win, 25);
        for (int w = 0; w < 64; w += 21) begin
            do_cmd(0, w, 0, 1, rd, tmo);
            check(rd == 16'h5AA5, "R3 write-all result", rd, 16'h5AA5);
        end
        do_cmd(5, 0, 0, 0, rd, tmo);
        check(tmo == 0, "R7 erase-all ready", tmo, 0);
        do_cmd(0, 100, 0, 0, rd, tmo);
        check(rd == 8'hFF, "R3 erase-all result", rd, 8'hFF);

        // R8 timeout on a memory that stays busy
        busy_len = 1000;
        do_cmd(1, 1, 16'h1111, 1, rd, tmo);
        check(tmo == 1, "R8 timeout flagged", tmo, 1);
        repeat (1100) @(negedge clk);
        busy_len = 40;
        do_cmd(0, 1, 0, 1, rd, tmo);
        check(tmo == 0 && rd == 16'h1111, "R8 later read clean", rd, 16'h1111);

        check(tviol == 0, "R5 R6 link timing", tviol, 0);
        check(hs_err == 0, "R9 handshake", hs_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule